// File: doc/BRIEF.md
# Stereo Audio Serial Link

This block moves two-channel audio between a pair of word FIFOs and a three-wire serial link made of a bit clock, a frame sync and a data line. Each frame is one 32-bit FIFO word. The upper 16 bits are the left sample and the lower 16 bits are the right sample. Bits go out MSB first. Data is launched on the falling bit-clock edge and captured on the rising edge.

Two framings are available. In standard I2S framing the frame sync is low for the left channel and changes one bit period before each MSB. In MSB-justified framing the frame sync is high for the left channel and changes in the same bit period as the MSB.

The block can act as timing master. In that case it divides the system clock to make the bit clock and derives the frame sync from its own bit counter. It can also act as slave. In that case it takes the bit clock and frame sync from pins through a synchronizer and re-aligns its bit counter on every frame-sync edge.

Playback and record each have their own disable. The link stops only when both are disabled or the global enable is low. A loopback switch feeds the transmitted data straight into the receive shifter.

Top module: `audio_link_ser`

## Requirements
- R1: After reset, sck_out, fs_out, sd_out, tx_pop, rx_push and rx_word are all 0.
- R2: When left_just is 0 (I2S framing), the link behaves as follows:
  - fs_out is low while the left sample is sent.
  - The left MSB (word bit 31) occupies the first bit period after fs_out falls.
  - The 32 word bits follow MSB first, one per bit clock.
  - Each bit is launched after a falling edge of sck_out and is stable at the next rising edge.
- R3: When left_just is 1 (MSB-justified framing), fs_out is high while the left sample is sent, and word bit 31 occupies the same bit period in which fs_out rises.
- R4: Bit-clock direction depends on clk_drive:
  - With clk_drive at 1, sck_out toggles every div_half+1 system clocks, so its period is 2*(div_half+1) clocks.
  - With clk_drive at 0, sck_out and fs_out are held at 0, and all bit timing comes from sck_in and fs_in.
- R5: With loop_en at 1 and playback and record both enabled, the words on rx_word equal the popped tx words in the same order, with one rx_push pulse per frame.
- R6: While play_off is 1:
  - sd_out stays 0 and tx_pop never pulses.
  - Record keeps running, so loopback delivers all-zero words.
- R7: While rec_off is 1, rx_push never pulses, and playback keeps popping words.
- R8: While link_en is 0, or while play_off and rec_off are both 1, the link is idle:
  - sck_out stays at 0.
  - No tx_pop occurs and no rx_push occurs.
- R9: If tx_avail is 0 at the falling edge that starts a frame, that frame carries all zeros and no tx_pop pulse is issued.
- R10: In slave mode the receiver rebuilds words from sd_in using the external sck_in and fs_in, for both framings. Each pin passes through a two-stage synchronizer first. After the first frame-sync edge, every pushed word equals the word that was sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| link_en | input | 1 | Global link enable |
| left_just | input | 1 | 1: MSB-justified framing, 0: I2S framing |
| clk_drive | input | 1 | 1: block drives bit clock and frame sync, 0: takes them from pins |
| loop_en | input | 1 | Route transmit data into the receive shifter |
| play_off | input | 1 | Disable playback |
| rec_off | input | 1 | Disable record |
| div_half | input | 8 | Bit-clock half period minus one, in system clocks |
| sck_in | input | 1 | External bit clock (slave mode) |
| fs_in | input | 1 | External frame sync (slave mode) |
| sd_in | input | 1 | Serial receive data |
| sck_out | output | 1 | Generated bit clock (master mode) |
| fs_out | output | 1 | Generated frame sync (master mode) |
| sd_out | output | 1 | Serial transmit data |
| tx_avail | input | 1 | Transmit FIFO holds a word |
| tx_word | input | 32 | Head word of the transmit FIFO, left sample in bits 31:16 |
| tx_pop | output | 1 | One-cycle pop of the transmit FIFO |
| rx_word | output | 32 | Last received frame, left sample in bits 31:16 |
| rx_push | output | 1 | One-cycle push of rx_word into the receive FIFO |

## Verification
The hardest state to reach from the ports is a slave link whose bit counter starts out of step with an external master. The counter must then lock onto the first frame-sync edge without pushing a corrupted word afterwards.

The bench acts as the external master. It starts its bit clock at an arbitrary phase relative to the block's idle counter and sends several frames of random and corner-case words in both framings. Only the first push, which may straddle the lock point, is excluded from comparison.

In master mode the bench decodes the serial line from fs_out and sd_out using the framing rules alone. It compares the decoded words with the FIFO contents, which makes a frame-sync offset error visible independently of loopback.

// File: rtl/audio_link_pkg.sv
package audio_link_pkg;

  typedef enum logic {
    FMT_I2S  = 1'b0,
    FMT_MSBJ = 1'b1
  } frame_fmt_e;

  // Frame-sync level for the bit period of a given slot (slot 0 = left MSB).
  function automatic logic ws_level(input frame_fmt_e fmt, input int unsigned slot,
                                    input int unsigned half);
    if (fmt == FMT_MSBJ) return slot < half;
    // I2S: sync leads the data by one slot and is high for the right channel
    return (slot >= half - 1) && (slot <= 2 * half - 2);
  endfunction

endpackage

// File: rtl/als_bitclk_gen.sv
module als_bitclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_half,
  output logic             sck,
  output logic             rise_p,
  output logic             fall_p
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt    <= '0;
      sck    <= 1'b0;
      rise_p <= 1'b0;
      fall_p <= 1'b0;
    end else begin
      rise_p <= 1'b0;
      fall_p <= 1'b0;
      if (cnt == div_half) begin
        cnt    <= '0;
        sck    <= ~sck;
        rise_p <= ~sck;
        fall_p <= sck;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/als_pin_sync.sv
module als_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_pin,
  input  logic fs_pin,
  input  logic sd_pin,
  output logic sck_rise,
  output logic sck_fall,
  output logic fs_q,
  output logic sd_q
);
  localparam int NPIN = 3;

  logic [STAGES-1:0][NPIN-1:0] chain;
  logic [NPIN-1:0]             pins;
  logic                        sck_d;

  assign pins = {sd_pin, fs_pin, sck_pin};

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      sck_d <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], pins};
      sck_d <= chain[STAGES-1][0];
    end
  end

  assign sck_rise = chain[STAGES-1][0] & ~sck_d;
  assign sck_fall = ~chain[STAGES-1][0] & sck_d;
  assign fs_q     = chain[STAGES-1][1];
  assign sd_q     = chain[STAGES-1][2];
endmodule

// File: rtl/als_tx_path.sv
module als_tx_path #(
  parameter int FRAME_W = 32,
  parameter int SLOT_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               fall_p,
  input  logic [SLOT_W-1:0]  slot_nxt,
  input  logic               avail,
  input  logic [FRAME_W-1:0] word,
  output logic               sd,
  output logic               pop
);
  localparam logic [SLOT_W-1:0] TOP = SLOT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] shreg;
  logic [SLOT_W-1:0]  idx;

  assign idx = TOP - slot_nxt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      shreg <= '0;
      sd    <= 1'b0;
      pop   <= 1'b0;
    end else begin
      pop <= 1'b0;
      if (fall_p) begin
        if (slot_nxt == '0) begin
          shreg <= avail ? word : '0;
          sd    <= avail & word[FRAME_W-1];
          pop   <= avail;
        end else begin
          sd <= shreg[idx];
        end
      end
    end
  end
endmodule

// File: rtl/als_rx_path.sv
module als_rx_path #(
  parameter int FRAME_W = 32,
  parameter int SLOT_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               rise_p,
  input  logic [SLOT_W-1:0]  slot,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] word,
  output logic               push
);
  localparam logic [SLOT_W-1:0] TOP = SLOT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] shreg;
  logic               armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
    end else if (en && rise_p && armed && slot == TOP) begin
      word <= {shreg[FRAME_W-2:0], bit_in};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      shreg <= '0;
      armed <= 1'b0;
      push  <= 1'b0;
    end else begin
      push <= 1'b0;
      if (rise_p) begin
        shreg <= {shreg[FRAME_W-2:0], bit_in};
        if (slot == '0) armed <= 1'b1;
        if (slot == TOP && armed) push <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/audio_link_ser.sv
module audio_link_ser
  import audio_link_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  link_en,
  input  logic                  left_just,
  input  logic                  clk_drive,
  input  logic                  loop_en,
  input  logic                  play_off,
  input  logic                  rec_off,
  input  logic [DIV_W-1:0]      div_half,
  input  logic                  sck_in,
  input  logic                  fs_in,
  input  logic                  sd_in,
  output logic                  sck_out,
  output logic                  fs_out,
  output logic                  sd_out,
  input  logic                  tx_avail,
  input  logic [2*SAMPLE_W-1:0] tx_word,
  output logic                  tx_pop,
  output logic [2*SAMPLE_W-1:0] rx_word,
  output logic                  rx_push
);
  localparam int FRAME_W = 2 * SAMPLE_W;
  localparam int SLOT_W  = $clog2(FRAME_W);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(FRAME_W - 1);

  logic              active, m_run;
  logic              m_rise, m_fall, s_rise, s_fall, s_fs, s_sd;
  logic              rise_e, fall_e;
  logic [SLOT_W-1:0] slot, slot_nxt, resync_val;
  logic              fs_r, fs_rr, resync;
  logic              rx_bit;
  frame_fmt_e        fmt;

  assign fmt    = frame_fmt_e'(left_just);
  assign active = link_en & ~(play_off & rec_off);
  assign m_run  = active & clk_drive;

  als_bitclk_gen #(.DIV_W(DIV_W)) u_gen (
    .clk(clk), .rst(rst), .run(m_run), .div_half(div_half),
    .sck(sck_out), .rise_p(m_rise), .fall_p(m_fall)
  );

  als_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck_pin(sck_in), .fs_pin(fs_in), .sd_pin(sd_in),
    .sck_rise(s_rise), .sck_fall(s_fall), .fs_q(s_fs), .sd_q(s_sd)
  );

  assign rise_e = active & (clk_drive ? m_rise : s_rise);
  assign fall_e = active & (clk_drive ? m_fall : s_fall);

  // Slave alignment: the frame sync seen at the last two rising edges
  always_comb begin
    resync     = 1'b0;
    resync_val = '0;
    if (!clk_drive) begin
      if (fmt == FMT_MSBJ) begin
        resync     = fs_r & ~fs_rr;
        resync_val = SLOT_W'(1);
      end else begin
        resync     = fs_rr & ~fs_r;
      end
    end
    if (resync)                 slot_nxt = resync_val;
    else if (slot == SLOT_LAST) slot_nxt = '0;
    else                        slot_nxt = slot + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      slot  <= SLOT_LAST;
      fs_r  <= 1'b0;
      fs_rr <= 1'b0;
    end else begin
      if (rise_e) begin
        fs_r  <= s_fs;
        fs_rr <= fs_r;
      end
      if (fall_e) slot <= slot_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !active || !clk_drive) fs_out <= 1'b0;
    else if (fall_e) fs_out <= ws_level(fmt, int'(slot_nxt), SAMPLE_W);
  end

  als_tx_path #(.FRAME_W(FRAME_W), .SLOT_W(SLOT_W)) u_tx (
    .clk(clk), .rst(rst), .en(active & ~play_off), .fall_p(fall_e),
    .slot_nxt(slot_nxt), .avail(tx_avail), .word(tx_word),
    .sd(sd_out), .pop(tx_pop)
  );

  assign rx_bit = loop_en ? sd_out : s_sd;

  als_rx_path #(.FRAME_W(FRAME_W), .SLOT_W(SLOT_W)) u_rx (
    .clk(clk), .rst(rst), .en(active & ~rec_off), .rise_p(rise_e),
    .slot(slot), .bit_in(rx_bit), .word(rx_word), .push(rx_push)
  );
endmodule

// File: rtl/audio_link_chk.sv
module audio_link_chk (
  input logic clk,
  input logic rst,
  input logic link_en,
  input logic clk_drive,
  input logic play_off,
  input logic rec_off,
  input logic tx_avail,
  input logic sck_out,
  input logic fs_out,
  input logic sd_out,
  input logic tx_pop,
  input logic rx_push
);
  assert_slave_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(clk_drive) |-> (!sck_out && !fs_out));

  assert_no_pop_play_off_R6: assert property (@(posedge clk) disable iff (rst)
    (play_off && $past(play_off)) |-> (!tx_pop && !sd_out));

  assert_no_push_rec_off_R7: assert property (@(posedge clk) disable iff (rst)
    (rec_off && $past(rec_off)) |-> !rx_push);

  assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(link_en) |-> (!sck_out && !sd_out && !fs_out && !tx_pop));

  assert_pop_needs_data_R9: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> $past(tx_avail));

  assert_push_single_R5: assert property (@(posedge clk) disable iff (rst)
    rx_push |=> !rx_push);
endmodule

bind audio_link_ser audio_link_chk u_chk (
  .clk(clk), .rst(rst), .link_en(link_en), .clk_drive(clk_drive),
  .play_off(play_off), .rec_off(rec_off), .tx_avail(tx_avail),
  .sck_out(sck_out), .fs_out(fs_out), .sd_out(sd_out),
  .tx_pop(tx_pop), .rx_push(rx_push)
);

// File: tb/audio_link_ser_tb.sv
module audio_link_ser_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, link_en = 1'b0, left_just = 1'b0, clk_drive = 1'b1;
  logic loop_en = 1'b1, play_off = 1'b0, rec_off = 1'b0;
  logic [7:0] div_half = 8'd3;
  logic sck_in = 1'b0, fs_in = 1'b0, sd_in = 1'b0;
  logic sck_out, fs_out, sd_out, tx_avail = 1'b1, tx_pop, rx_push;
  logic [31:0] tx_word, rx_word;

  logic [31:0] words [64];
  int total = 0, bad = 0;
  int base = 0, tx_idx = 0, rx_n = 0, mon_n = 0;
  int pop_cnt = 0, push_cnt = 0, rise_cnt = 0, sd_hi_cnt = 0;
  int rx_mode = 0, cyc = 0, last_rise = -1, bitcnt = -1;
  string rx_tag = "R5";
  bit clr = 1'b0, mon_en = 1'b0, per_done = 1'b0, prev_fs = 1'b1, prev_sck = 1'b0;
  logic [31:0] acc = '0, slave_exp = '0;

  assign tx_word = words[(base + tx_idx) % 64];

  audio_link_ser u_dut (
    .clk(clk), .rst(rst), .link_en(link_en), .left_just(left_just),
    .clk_drive(clk_drive), .loop_en(loop_en), .play_off(play_off),
    .rec_off(rec_off), .div_half(div_half), .sck_in(sck_in), .fs_in(fs_in),
    .sd_in(sd_in), .sck_out(sck_out), .fs_out(fs_out), .sd_out(sd_out),
    .tx_avail(tx_avail), .tx_word(tx_word), .tx_pop(tx_pop),
    .rx_word(rx_word), .rx_push(rx_push)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: FIFO model, counters, serial decoder, receive checks
  always @(negedge clk) begin
    cyc++;
    if (clr) begin
      tx_idx = 0; rx_n = 0; mon_n = 0; pop_cnt = 0; push_cnt = 0;
      rise_cnt = 0; sd_hi_cnt = 0; bitcnt = -1; last_rise = -1;
      per_done = 1'b0; prev_sck = 1'b0; prev_fs = !left_just;
    end else begin
      if (tx_pop) begin tx_idx++; pop_cnt++; end
      if (sd_out) sd_hi_cnt++;
      if (rx_push) begin
        push_cnt++;
        case (rx_mode)
          1: chk(rx_word == words[(base + rx_n) % 64], rx_tag, rx_word, words[(base + rx_n) % 64]);
          2: chk(rx_word == 32'h0, rx_tag, rx_word, 32'h0);
          3: if (rx_n >= 1) chk(rx_word == slave_exp, rx_tag, rx_word, slave_exp);
          default: ;
        endcase
        rx_n++;
      end
      if (sck_out && !prev_sck) begin
        rise_cnt++;
        if (mon_en) begin
          if (last_rise >= 0 && !per_done) begin
            chk(cyc - last_rise == 2 * (int'(div_half) + 1), "R4",
                32'(cyc - last_rise), 32'(2 * (int'(div_half) + 1)));
            per_done = 1'b1;
          end
          if (bitcnt >= 0) begin
            acc = {acc[30:0], sd_out};
            bitcnt++;
            if (bitcnt == 32) begin
              chk(acc == words[(base + mon_n) % 64], left_just ? "R3" : "R2",
                  acc, words[(base + mon_n) % 64]);
              mon_n++;
              bitcnt = -1;
            end
          end
          if (!left_just && prev_fs && !fs_out) bitcnt = 0;
          else if (left_just && !prev_fs && fs_out) begin
            acc = {31'b0, sd_out};
            bitcnt = 1;
          end
          prev_fs = fs_out;
        end
        last_rise = cyc;
      end
      prev_sck = sck_out;
    end
  end

  task automatic start_phase(input int b, input bit en);
    @(negedge clk);
    base = b;
    @(posedge clk); clr = 1'b1;
    @(posedge clk); clr = 1'b0;
    @(negedge clk);
    link_en = en;
  endtask

  task automatic stop_phase();
    @(negedge clk);
    link_en = 1'b0; mon_en = 1'b0; rx_mode = 0;
    repeat (10) @(negedge clk);
  endtask

  // External master: half period of 6 clocks, data and sync change on the fall
  task automatic slave_frames(input int nfr, input bit mj);
    logic [31:0] w;
    for (int f = 0; f < nfr; f++) begin
      w = words[(40 + f) % 64];
      for (int b = 0; b < 32; b++) begin
        @(negedge clk);
        sck_in = 1'b0;
        sd_in  = w[31 - b];
        fs_in  = mj ? (b < 16) : (b >= 15 && b <= 30);
        repeat (5) @(negedge clk);
        sck_in = 1'b1;
        if (b == 31) slave_exp = w;
        repeat (5) @(negedge clk);
      end
    end
    @(negedge clk);
    sck_in = 1'b0; fs_in = 1'b0; sd_in = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    words[0] = $urandom(32'h1234_5678);
    for (int i = 0; i < 64; i++) words[i] = $urandom();
    words[0] = 32'h8000_0001;
    words[1] = 32'h0001_8000;
    words[2] = 32'hFFFF_FFFF;
    words[3] = 32'h0000_0000;
    words[4] = 32'hAAAA_5555;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sck_out == 1'b0, "R1", 32'(sck_out), 0);
    chk(fs_out == 1'b0, "R1", 32'(fs_out), 0);
    chk(sd_out == 1'b0, "R1", 32'(sd_out), 0);
    chk(tx_pop == 1'b0 && rx_push == 1'b0, "R1", {30'b0, tx_pop, rx_push}, 0);
    chk(rx_word == 32'h0, "R1", rx_word, 0);

    // R2 and R5: master, I2S, loopback
    left_just = 1'b0; clk_drive = 1'b1; loop_en = 1'b1; div_half = 8'd3;
    rx_mode = 1; rx_tag = "R5"; mon_en = 1'b1;
    start_phase(0, 1'b1);
    repeat (32 * 8 * 6) @(negedge clk);
    chk(mon_n >= 5, "R2", 32'(mon_n), 5);
    chk(rx_n >= 5 && rx_n == push_cnt, "R5", 32'(rx_n), 5);
    stop_phase();

    // R3: master, MSB-justified, random divider
    left_just = 1'b1; div_half = 8'(2 + $urandom() % 4);
    rx_mode = 1; rx_tag = "R5"; mon_en = 1'b1;
    start_phase(16, 1'b1);
    repeat (32 * 2 * (int'(div_half) + 1) * 6) @(negedge clk);
    chk(mon_n >= 5, "R3", 32'(mon_n), 5);
    stop_phase();

    // R6: playback disabled, record on, loopback gives zero words
    left_just = 1'b0; div_half = 8'd3; play_off = 1'b1;
    rx_mode = 2; rx_tag = "R6";
    start_phase(24, 1'b1);
    repeat (32 * 8 * 4) @(negedge clk);
    chk(pop_cnt == 0, "R6", 32'(pop_cnt), 0);
    chk(sd_hi_cnt == 0, "R6", 32'(sd_hi_cnt), 0);
    chk(push_cnt >= 3, "R6", 32'(push_cnt), 3);
    stop_phase();

    // R7: record disabled, playback on
    play_off = 1'b0; rec_off = 1'b1;
    start_phase(24, 1'b1);
    repeat (32 * 8 * 4) @(negedge clk);
    chk(push_cnt == 0, "R7", 32'(push_cnt), 0);
    chk(pop_cnt >= 3, "R7", 32'(pop_cnt), 3);
    stop_phase();

    // R8: both disabled with the link enabled
    play_off = 1'b1; rec_off = 1'b1;
    start_phase(24, 1'b1);
    repeat (600) @(negedge clk);
    chk(rise_cnt == 0, "R8", 32'(rise_cnt), 0);
    chk(pop_cnt == 0 && push_cnt == 0, "R8", 32'(pop_cnt + push_cnt), 0);
    stop_phase();

    // R8: everything enabled but the global enable low
    play_off = 1'b0; rec_off = 1'b0;
    start_phase(24, 1'b0);
    repeat (600) @(negedge clk);
    chk(rise_cnt == 0 && pop_cnt == 0 && push_cnt == 0, "R8",
        32'(rise_cnt + pop_cnt + push_cnt), 0);
    stop_phase();

    // R9: transmit FIFO empty
    tx_avail = 1'b0; rx_mode = 2; rx_tag = "R9";
    start_phase(24, 1'b1);
    repeat (32 * 8 * 4) @(negedge clk);
    chk(pop_cnt == 0, "R9", 32'(pop_cnt), 0);
    chk(push_cnt >= 3, "R9", 32'(push_cnt), 3);
    stop_phase();
    tx_avail = 1'b1;

    // R10 and R4: slave mode, I2S then MSB-justified
    for (int m = 0; m < 2; m++) begin
      clk_drive = 1'b0; loop_en = 1'b0; left_just = (m == 1);
      rx_mode = 3; rx_tag = "R10";
      start_phase(32, 1'b1);
      slave_frames(6, m == 1);
      repeat (20) @(negedge clk);
      chk(rise_cnt == 0, "R4", 32'(rise_cnt), 0);
      chk(push_cnt >= 4, "R10", 32'(push_cnt), 4);
      stop_phase();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule